// File: doc/BRIEF.md
# Timed Average Period Meter

This block measures the average period of a clean digital pulse train over a measurement window whose length the host sets. In each window it counts base-clock cycles from the first selected edge to the last one, and it counts how many selected edges came after the first. When the window closes, both numbers are published together so that software can divide them to get the mean period, or the mean frequency. A new window starts on the next cycle with no gap.

Measurement starts when the block is enabled. If trigger waiting is selected, it starts instead on a trigger pulse that arrives while the block is enabled. The active edge, rising or falling, is selectable. A window that holds fewer than two selected edges publishes zero in both results. Each publish comes with a one-cycle valid strobe. An interrupt strobe accompanies only those publishes that carry a usable, non-zero result.

Top module: `avg_period_meter`

## Requirements
- R1: After reset, result_time and result_count are 0, and result_valid and irq are low.
- R2: With trig_wait = 0, measurement starts on the first clock edge at which run_en is high. With trig_wait = 1, it starts only on a clock edge at which both run_en and trig_in are high. A trig_in pulse while a measurement is running has no effect.
- R3: A window lasts win_len clock cycles, and a win_len of 0 is treated as 1. Windows follow each other back to back. Each window ends with exactly one result_valid pulse of one cycle, in the cycle after its last window cycle.
- R4: result_count equals the number of selected edges in the window minus one, which is the number of intervals measured.
- R5: result_time equals the number of clock cycles from the first selected edge in the window to the last one.
- R6: A window with zero or one selected edge publishes 0 in both result_time and result_count, and still pulses result_valid.
- R7: edge_fall = 0 selects rising edges of sig_in and edge_fall = 1 selects falling edges. Edges of the other polarity are not counted.
- R8: Lowering run_en stops the measurement on that clock edge, and the open window is not published. The results hold their last published values while the block is stopped.
- R9: irq pulses for one cycle together with result_valid only when the window held at least two selected edges. It stays low otherwise.
- R10: A selected edge in the last cycle of a window is counted in that window and not in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; time is counted in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Clean, synchronous pulse train to be measured |
| edge_fall | input | 1 | 0: rising edges; 1: falling edges |
| win_len | input | WIN_W (31) | Window length in clock cycles (0 acts as 1) |
| run_en | input | 1 | Enable; low stops measurement at once |
| trig_wait | input | 1 | 1: wait for trig_in before starting |
| trig_in | input | 1 | Start trigger pulse |
| result_time | output | TIME_W (32) | Cycles from first to last selected edge of the last window |
| result_count | output | CNT_W (32) | Intervals counted in the last window |
| result_valid | output | 1 | One-cycle strobe on each publish |
| irq | output | 1 | One-cycle strobe on a publish holding at least two edges |

## Verification
The hardest case to reach from the ports is an active edge that falls exactly in the last cycle of a window. This is also where the closing window and the opening one meet. Window lengths of 0 and 1, as well as windows that happen to hold zero or one edge, are also hard to reach. The stimulus drives a pseudo-random pulse train against a window length of 37, which is co-prime with its pattern, so that edges drift across every window phase, including the final cycle. It also drives periodic waves whose edge counts per window are known exactly. A behavioural model compares against the design on every clock, and directed checks pin down the boundaries.

// File: rtl/apm_pkg.sv
package apm_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/apm_edge_sel.sv
module apm_edge_sel
    import apm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic edge_fall,
    input  logic live,
    output logic hit
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t s_d, s_q;
    logic  rise_w, fall_w;
    edge_pol_e pol;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sig_in;
        pol      = edge_fall ? EDGE_FALL : EDGE_RISE;
        rise_w   = sig_in & ~s_q.prev;
        fall_w   = ~sig_in & s_q.prev;
        hit      = live & ((pol == EDGE_FALL) ? fall_w : rise_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !edge_fall) |-> sig_in);
    // R7
    fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && edge_fall) |-> !sig_in);
endmodule

// File: rtl/apm_window_timer.sv
module apm_window_timer #(
    parameter int WIN_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             live,
    input  logic [WIN_W-1:0] win_len,
    output logic             expire
);
    localparam logic [WIN_W-1:0] WIN_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIN_W-1:0] cnt;
    } win_t;

    win_t s_d, s_q;
    logic [WIN_W-1:0] load_val;

    always_comb begin
        s_d      = s_q;
        load_val = (win_len == '0) ? WIN_ONE : win_len;
        expire   = live && (s_q.cnt == WIN_ONE);
        if (start) begin
            s_d.cnt = load_val;
        end else if (live) begin
            s_d.cnt = expire ? load_val : (s_q.cnt - WIN_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    win_live_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (s_q.cnt != '0));
endmodule

// File: rtl/apm_interval_core.sv
module apm_interval_core #(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              live,
    input  logic              hit,
    input  logic              expire,
    output logic [TIME_W-1:0] pub_time,
    output logic [CNT_W-1:0]  pub_count,
    output logic              pub_ok
);
    localparam logic [TIME_W-1:0] TIME_ONE = {{(TIME_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              seen;
        logic [TIME_W-1:0] tic;
        logic [TIME_W-1:0] lti;
        logic [CNT_W-1:0]  pnc;
    } core_t;

    core_t s_d, s_q;
    logic              late_hit;
    logic [CNT_W-1:0]  fin_cnt;
    logic [TIME_W-1:0] fin_time;

    // closing values, including an edge in the window's last cycle
    always_comb begin
        late_hit  = hit && s_q.seen;
        fin_cnt   = late_hit ? (s_q.pnc + CNT_ONE) : s_q.pnc;
        fin_time  = late_hit ? s_q.tic : s_q.lti;
        pub_ok    = s_q.seen && (fin_cnt != '0);
        pub_count = pub_ok ? fin_cnt : '0;
        pub_time  = pub_ok ? fin_time : '0;
    end

    always_comb begin
        s_d = s_q;
        if (clear || expire) begin
            s_d = '0;
        end else if (hit) begin
            if (!s_q.seen) begin
                s_d.seen = 1'b1;
                s_d.tic  = TIME_ONE;
                s_d.lti  = '0;
                s_d.pnc  = '0;
            end else begin
                s_d.lti = s_q.tic;
                s_d.pnc = s_q.pnc + CNT_ONE;
                s_d.tic = s_q.tic + TIME_ONE;
            end
        end else if (s_q.seen && live) begin
            s_d.tic = s_q.tic + TIME_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    pnc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.seen && !clear && !expire) |=>
            ((s_q.pnc == $past(s_q.pnc)) || (s_q.pnc == $past(s_q.pnc) + CNT_ONE)));
    // R5
    tic_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.seen && s_q.pnc != '0) |-> (s_q.tic > s_q.lti));
endmodule

// File: rtl/avg_period_meter.sv
module avg_period_meter
    import apm_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 32,
    parameter int WIN_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              edge_fall,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              run_en,
    input  logic              trig_wait,
    input  logic              trig_in,
    output logic [TIME_W-1:0] result_time,
    output logic [CNT_W-1:0]  result_count,
    output logic              result_valid,
    output logic              irq
);
    typedef struct packed {
        ctl_state_e        st;
        logic [TIME_W-1:0] r_time;
        logic [CNT_W-1:0]  r_count;
        logic              valid;
        logic              irq;
    } top_t;

    top_t s_d, s_q;
    logic live, start, hit, expire, pub_ok;
    logic [TIME_W-1:0] pub_time;
    logic [CNT_W-1:0]  pub_count;

    always_comb begin
        live  = (s_q.st == CTL_RUN) && run_en;
        start = (s_q.st == CTL_IDLE) && run_en && (!trig_wait || trig_in);
    end

    apm_edge_sel u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .edge_fall (edge_fall),
        .live      (live),
        .hit       (hit)
    );

    apm_window_timer #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .live    (live),
        .win_len (win_len),
        .expire  (expire)
    );

    apm_interval_core #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .live      (live),
        .hit       (hit),
        .expire    (expire),
        .pub_time  (pub_time),
        .pub_count (pub_count),
        .pub_ok    (pub_ok)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = expire;
        s_d.irq   = expire && pub_ok;
        if (!run_en)    s_d.st = CTL_IDLE;
        else if (start) s_d.st = CTL_RUN;
        if (expire) begin
            s_d.r_time  = pub_time;
            s_d.r_count = pub_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result_time  = s_q.r_time;
    assign result_count = s_q.r_count;
    assign result_valid = s_q.valid;
    assign irq          = s_q.irq;

    // R8
    stop_no_pub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !result_valid);
    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(result_time) && $stable(result_count)));
    // R9
    irq_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (result_valid && result_count != '0));
    // R6
    zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && result_count == '0) |-> (result_time == '0 && !irq));
    // R5
    time_ge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result_time >= result_count));
endmodule

// File: tb/avg_period_meter_tb_top.sv
module avg_period_meter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic        edge_fall = 1'b0;
    logic [30:0] win_len = 31'd0;
    logic        run_en = 1'b0;
    logic        trig_wait = 1'b0;
    logic        trig_in = 1'b0;
    logic [31:0] result_time;
    logic [31:0] result_count;
    logic        result_valid;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int tb_cyc  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    avg_period_meter dut_i (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .edge_fall(edge_fall),
        .win_len(win_len), .run_en(run_en), .trig_wait(trig_wait), .trig_in(trig_in),
        .result_time(result_time), .result_count(result_count),
        .result_valid(result_valid), .irq(irq)
    );

    // behavioural reference: edge times per window
    bit m_run, m_prev, m_live, m_hit;
    int m_rem, m_n, m_first, m_last, m_cyc;
    int e_time, e_cnt;
    bit e_valid, e_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_prev = 0; m_rem = 0; m_n = 0; m_first = 0; m_last = 0;
            e_time = 0; e_cnt = 0; e_valid = 0; e_irq = 0;
        end else begin
            m_live = m_run && run_en;
            m_hit  = m_live && (edge_fall ? (!sig_in && m_prev) : (sig_in && !m_prev));
            e_valid = 0; e_irq = 0;
            if (m_live) begin
                if (m_hit) begin
                    m_n++;
                    if (m_n == 1) m_first = m_cyc;
                    m_last = m_cyc;
                end
                if (m_rem == 1) begin
                    if (m_n >= 2) begin
                        e_time = m_last - m_first; e_cnt = m_n - 1; e_irq = 1;
                    end else begin
                        e_time = 0; e_cnt = 0;
                    end
                    e_valid = 1; m_n = 0;
                    m_rem = (win_len == 0) ? 1 : int'(win_len);
                end else begin
                    m_rem--;
                end
            end else if (!m_run && run_en && (!trig_wait || trig_in)) begin
                m_run = 1; m_n = 0;
                m_rem = (win_len == 0) ? 1 : int'(win_len);
            end
            if (!run_en) m_run = 0;
            m_prev = sig_in;
        end
        m_cyc++;
        tb_cyc++;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(result_time == 32'(e_time), "R5 R10", "result_time", result_time, e_time);
            check(result_count == 32'(e_cnt), "R4 R10", "result_count", result_count, e_cnt);
            check(result_valid == e_valid, "R3", "result_valid", result_valid, e_valid);
            check(irq == e_irq, "R9", "irq", irq, e_irq);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (tb_cyc > 150000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", tb_cyc, 150000);
            finish_run();
        end
    end

    task automatic square(int period, int high, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            sig_in = ((i % period) < high);
        end
    endtask

    task automatic wait_valid(int limit, output bit got);
        got = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (result_valid) begin got = 1; break; end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        bit got;
        int t1, t2, nv;
        logic [31:0] sv_time, sv_cnt;
        idle(3);
        check(result_time == 0 && result_count == 0, "R1", "reset results", result_time, 0);
        check(!result_valid && !irq, "R1", "reset strobes", {result_valid, irq}, 0);
        rst_n = 1'b1;
        idle(2);

        // periodic rising edges, period 10, window 100: always 10 edges
        win_len = 31'd100; edge_fall = 0; trig_wait = 0; run_en = 1;
        fork
            square(10, 5, 450);
            begin
                wait_valid(200, got);
                wait_valid(200, got); t1 = tb_cyc;
                check(got && result_count == 9, "R4", "intervals in window", result_count, 9);
                check(result_time == 90, "R5", "first-to-last cycles", result_time, 90);
                check(irq == 1, "R9", "irq on good window", irq, 1);
                wait_valid(200, got); t2 = tb_cyc;
                check(got && (t2 - t1) == 100, "R3", "publish spacing", t2 - t1, 100);
            end
        join
        run_en = 0; idle(3);

        // falling edges, period 7, high 2
        edge_fall = 1; run_en = 1;
        fork
            square(7, 2, 400);
            begin
                wait_valid(200, got);
                wait_valid(200, got);
                check(got && result_time == result_count * 7, "R7", "falling average", result_time, result_count * 7);
                check(result_count >= 13, "R7", "falling count", result_count, 13);
            end
        join
        run_en = 0; idle(3);

        // flat signal: no edges
        sig_in = 0; edge_fall = 0; win_len = 31'd50; run_en = 1;
        wait_valid(100, got);
        check(got && result_time == 0 && result_count == 0, "R6", "zero on no edges", result_count, 0);
        check(irq == 0, "R9", "no irq on empty window", irq, 0);
        run_en = 0; idle(3);

        // stop mid-window
        win_len = 31'd1000; run_en = 1;
        fork
            square(9, 4, 1700);
            begin
                idle(300);
                run_en = 0;
                idle(1);
                sv_time = result_time; sv_cnt = result_count; nv = 0;
                for (int i = 0; i < 1200; i++) begin
                    @(negedge clk); if (result_valid) nv++;
                end
                check(nv == 0, "R8", "no publish after stop", nv, 0);
                check(result_time == sv_time && result_count == sv_cnt, "R8", "results held", result_count, sv_cnt);
            end
        join

        // trigger wait
        win_len = 31'd5; trig_wait = 1; run_en = 1; nv = 0;
        fork
            square(3, 1, 140);
            begin
                for (int i = 0; i < 60; i++) begin
                    @(negedge clk); if (result_valid) nv++;
                end
                check(nv == 0, "R2", "no start without trigger", nv, 0);
                trig_in = 1; @(negedge clk); trig_in = 0;
                wait_valid(10, got);
                check(got, "R2", "start on trigger", got, 1);
                idle(7); trig_in = 1; @(negedge clk); trig_in = 0;
                idle(20);
            end
        join
        run_en = 0; trig_wait = 0; idle(3);

        // zero window length acts as one
        win_len = 31'd0; run_en = 1; idle(2); nv = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); if (result_valid) nv++;
        end
        check(nv == 5, "R3", "one-cycle windows", nv, 5);
        run_en = 0; idle(3);

        // pseudo-random signal, edges land on every window phase
        win_len = 31'd37; run_en = 1;
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                sig_in = lfsr[0];
                if (i == 1500) edge_fall = 1;
            end
        end
        run_en = 0; idle(5);
        finish_run();
    end
endmodule